// File: doc/BRIEF.md
# Console Terminal and Line Clock Register Block

This block is a small memory-mapped register file on a processor's internal bus. It holds four devices at fixed addresses in the top 256-byte page. The first is a keyboard receiver that takes characters from an external serial shifter. The second is a printer transmitter that hands characters to an external serial shifter. The third is a line-time clock that raises a flag at a fixed rate. The fourth is a read-only switch register. Each access is a single-cycle request. A response carrying the read data follows one cycle later, and only for addresses the block owns.

Each register bit is modelled exactly, including its side effects. Reading the receive buffer drains it. Writing the transmit buffer starts a transfer. A status write that sets an interrupt enable while its device is already ready raises the interrupt flag at once. The clock flag is cleared by writing a zero into it. Three interrupt request lines come out, one per source. A per-source acknowledge input clears the request flag when the processor takes the interrupt. Serial bit timing and vector generation belong to other blocks.

Top module: `conclk_regfile`

## Requirements
- R1: After synchronous reset, the transmitter status reads 0x0080 (ready and its flag set). The receiver status, receiver buffer and clock status read 0, and `rsp_valid`, `tx_valid` and all three `irq_*` outputs are 0.
- R2: A request whose address lies in page 0xFF00-0xFFFF and matches a mapped offset gets `rsp_valid` high in the following cycle, with read data on `rsp_rdata`. Any other address gets no response.
- R3: Receiver status (octal 177560) holds: bit 7 receive flag, bit 6 interrupt enable, bit 1 busy (follows `rx_busy`), bit 0 reader enable. A write sets only bits 6 and 0.
- R4: A read of the receiver buffer (177562) returns the held character in bits 7:0. The same read clears the buffer, the data-available state and the receive flag.
- R5: A byte on `rx_valid`/`rx_data` loads the buffer, sets data-available and the receive flag, and clears reader enable. When it coincides with a buffer read, the read returns the old character and the new one is kept.
- R6: Transmitter status (177564) holds: bit 7 transmit flag, bit 6 interrupt enable, bit 2 maintenance (read/write). The transmitter buffer (177566) reads as 0.
- R7: A write to the transmitter buffer drives bits 6:0 of the data onto `tx_data` with `tx_valid` high, and clears ready and the transmit flag.
- R8: A cycle with `tx_valid` and `tx_ready` both high completes the transfer. `tx_valid` drops, and ready and the transmit flag are set.
- R9: A status write that changes interrupt enable from 0 to 1 sets the flag if the receiver holds data (receiver) or the transmitter is ready (transmitter). A write that leaves enable at 1 does not set the flag.
- R10: Clock status (177546) holds bit 7 tick flag and bit 6 interrupt enable. The tick flag is set every TICK_DIV cycles. A write with bit 7 clear clears it, and a write with bit 7 set leaves it unchanged.
- R11: Each `irq_*` output is its source's request flag AND its enable. `irq_ack` bit 0 (receiver), bit 1 (transmitter) and bit 2 (clock) clear the request flag. The clock's status bit 7 is not cleared by an acknowledge.
- R12: The switch register reads `sw_in` at both 177570 and 177571, and writes to it change nothing.
- R13: The odd byte addresses 177547, 177561, 177563, 177565 and 177567 respond with 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| sw_in | input | 16 | Switch register value |
| rx_valid | input | 1 | Received byte strobe from shifter |
| rx_data | input | 8 | Received byte |
| rx_busy | input | 1 | Shifter is assembling a byte |
| tx_valid | output | 1 | Character waiting for the shifter |
| tx_data | output | 7 | Character to send |
| tx_ready | input | 1 | Shifter accepts the character |
| irq_ack | input | 3 | Acknowledge: [0] rx, [1] tx, [2] clock |
| irq_rx | output | 1 | Receiver interrupt request |
| irq_tx | output | 1 | Transmitter interrupt request |
| irq_clk | output | 1 | Clock interrupt request |

## Verification
The bench targets a buffer read that lands in the same cycle as a new byte. A design with the wrong priority would lose the new character or return it early. It arms an interrupt enable after an acknowledge, while the device is already ready. A design missing the 0-to-1 rule would never raise the request, and a level-based design would raise it again on a repeated write. It measures the tick spacing exactly and clears the flag by writing zero. An off-by-one divider or an inverted clear sense shows up as a wrong cycle count or a stuck flag. The odd-byte and switch addresses are written and then read back, to catch decoding that lets a write leak into a neighbouring register.

// File: rtl/conclk_pkg.sv
package conclk_pkg;

    localparam int WORD_W  = 16;
    localparam int CHAR_W  = 8;
    localparam int TX_BITS = 7;

    localparam logic [7:0] PAGE_TAG = 8'hFF;

    // status bit positions (software decodes these)
    localparam int FLAG_BIT  = 7;
    localparam int IE_BIT    = 6;
    localparam int MAINT_BIT = 2;
    localparam int BUSY_BIT  = 1;
    localparam int RDR_BIT   = 0;

    localparam logic [7:0] OFS_CLK  = 8'o146;
    localparam logic [7:0] OFS_RXS  = 8'o160;
    localparam logic [7:0] OFS_RXB  = 8'o162;
    localparam logic [7:0] OFS_TXS  = 8'o164;
    localparam logic [7:0] OFS_TXB  = 8'o166;
    localparam logic [7:0] OFS_SWL  = 8'o170;
    localparam logic [7:0] OFS_SWH  = 8'o171;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CLK,
        SEL_RXS,
        SEL_RXB,
        SEL_TXS,
        SEL_TXB,
        SEL_SW,
        SEL_NULL
    } sel_e;

    typedef struct packed {
        logic clk_wr;
        logic rxs_wr;
        logic rxb_rd;
        logic txs_wr;
        logic txb_wr;
    } strobe_t;

    function automatic sel_e decode_addr(input logic [WORD_W-1:0] a);
        sel_e s;
        s = SEL_NONE;
        if (a[15:8] == PAGE_TAG) begin
            case (a[7:0])
                OFS_CLK:          s = SEL_CLK;
                OFS_RXS:          s = SEL_RXS;
                OFS_RXB:          s = SEL_RXB;
                OFS_TXS:          s = SEL_TXS;
                OFS_TXB:          s = SEL_TXB;
                OFS_SWL, OFS_SWH: s = SEL_SW;
                8'o147, 8'o161, 8'o163, 8'o165, 8'o167: s = SEL_NULL;
                default:          s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input logic flag, input logic ie,
                                                      input logic [5:0] low);
        return {8'h00, flag, ie, low};
    endfunction

endpackage

// File: rtl/conclk_rx_unit.sv
module conclk_rx_unit
    import conclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat,
    input  logic              rd_char,
    input  logic              ack,
    input  logic [CHAR_W-1:0] wdata_lo,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              busy_in,
    output logic [WORD_W-1:0] stat,
    output logic [WORD_W-1:0] char_word,
    output logic              irq
);

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              avail;
        logic              flag;
        logic              ie;
        logic              rdr_en;
    } rx_state_t;

    rx_state_t q, d;

    always_comb begin
        d = q;
        if (wr_stat) begin
            if (!q.ie && wdata_lo[IE_BIT] && q.avail)
                d.flag = 1'b1;
            d.ie     = wdata_lo[IE_BIT];
            d.rdr_en = wdata_lo[RDR_BIT];
        end
        if (ack)
            d.flag = 1'b0;
        if (rd_char) begin
            d.data  = '0;
            d.avail = 1'b0;
            d.flag  = 1'b0;
        end
        if (in_valid) begin
            d.data   = in_data;
            d.avail  = 1'b1;
            d.flag   = 1'b1;
            d.rdr_en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign stat      = status_word(q.flag, q.ie, {4'b0000, busy_in, q.rdr_en});
    assign char_word = {{(WORD_W-CHAR_W){1'b0}}, q.data};
    assign irq       = q.flag & q.ie;

    // R5
    rx_load_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (q.avail && q.flag && !q.rdr_en && q.data == $past(in_data)));

    // R4
    rx_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_char && !in_valid) |=> (!q.avail && !q.flag && q.data == '0));

    // R9
    rx_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !q.ie && wdata_lo[IE_BIT] && q.avail && !ack && !rd_char) |=> irq);

endmodule

// File: rtl/conclk_tx_unit.sv
module conclk_tx_unit
    import conclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_stat,
    input  logic               wr_char,
    input  logic               ack,
    input  logic [TX_BITS-1:0] wdata_lo,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [TX_BITS-1:0] out_data,
    output logic [WORD_W-1:0]  stat,
    output logic               irq
);

    typedef struct packed {
        logic [TX_BITS-1:0] data;
        logic               ready;
        logic               flag;
        logic               ie;
        logic               maint;
    } tx_state_t;

    localparam tx_state_t TX_RESET = '{data: '0, ready: 1'b1, flag: 1'b1, ie: 1'b0, maint: 1'b0};

    tx_state_t q, d;

    always_comb begin
        d = q;
        if (!q.ready && out_ready) begin
            d.ready = 1'b1;
            d.flag  = 1'b1;
        end
        if (wr_stat) begin
            if (!q.ie && wdata_lo[IE_BIT] && q.ready)
                d.flag = 1'b1;
            d.ie    = wdata_lo[IE_BIT];
            d.maint = wdata_lo[MAINT_BIT];
        end
        if (ack)
            d.flag = 1'b0;
        if (wr_char) begin
            d.data  = wdata_lo;
            d.ready = 1'b0;
            d.flag  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= TX_RESET;
        else     q <= d;
    end

    assign out_valid = !q.ready;
    assign out_data  = q.data;
    assign stat      = status_word(q.flag, q.ie, {3'b000, q.maint, 2'b00});
    assign irq       = q.flag & q.ie;

    // R7
    tx_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_char |=> (out_valid && !q.flag && out_data == $past(wdata_lo)));

    // R8
    tx_done_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !wr_char && !ack) |=> (!out_valid && q.flag));

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !wr_char) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/conclk_tick_unit.sv
module conclk_tick_unit
    import conclk_pkg::*;
#(
    parameter int TICK_DIV = 2083333
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat,
    input  logic              ack,
    input  logic [1:0]        wctl,      // {flag bit, enable bit} of the write
    output logic [WORD_W-1:0] stat,
    output logic              irq
);

    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

    typedef struct packed {
        logic tick_flag;
        logic req;
        logic ie;
    } clk_state_t;

    logic [CNT_W-1:0] cnt;
    logic             tick;
    clk_state_t       q, d;

    assign tick = (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    always_comb begin
        d = q;
        if (wr_stat) begin
            d.ie = wctl[0];
            if (!wctl[1]) begin
                d.tick_flag = 1'b0;
                d.req       = 1'b0;
            end
        end
        if (ack)
            d.req = 1'b0;
        if (tick) begin
            d.tick_flag = 1'b1;
            d.req       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign stat = status_word(q.tick_flag, q.ie, 6'b000000);
    assign irq  = q.req & q.ie;

    // R10
    clk_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !wctl[1] && !tick) |=> !stat[FLAG_BIT]);

    // R10
    clk_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (stat[FLAG_BIT] && !(wr_stat && !wctl[1])) |=> stat[FLAG_BIT]);

    // R11
    clk_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !tick) |=> !irq);

endmodule

// File: rtl/conclk_regfile.sv
module conclk_regfile
    import conclk_pkg::*;
#(
    parameter int TICK_DIV = 2083333
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [WORD_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_rdata,
    input  logic [WORD_W-1:0]  sw_in,
    input  logic               rx_valid,
    input  logic [CHAR_W-1:0]  rx_data,
    input  logic               rx_busy,
    output logic               tx_valid,
    output logic [TX_BITS-1:0] tx_data,
    input  logic               tx_ready,
    input  logic [2:0]         irq_ack,
    output logic               irq_rx,
    output logic               irq_tx,
    output logic               irq_clk
);

    sel_e              sel;
    logic              hit;
    strobe_t           stb;
    logic [WORD_W-1:0] rx_stat, rx_word, tx_stat, clk_stat, rd_mux;

    assign sel = decode_addr(req_addr);
    assign hit = req_valid && (sel != SEL_NONE);

    always_comb begin
        stb        = '0;
        stb.clk_wr = hit &&  req_write && (sel == SEL_CLK);
        stb.rxs_wr = hit &&  req_write && (sel == SEL_RXS);
        stb.rxb_rd = hit && !req_write && (sel == SEL_RXB);
        stb.txs_wr = hit &&  req_write && (sel == SEL_TXS);
        stb.txb_wr = hit &&  req_write && (sel == SEL_TXB);
    end

    conclk_rx_unit u_rx (
        .clk       (clk),
        .rst       (rst),
        .wr_stat   (stb.rxs_wr),
        .rd_char   (stb.rxb_rd),
        .ack       (irq_ack[0]),
        .wdata_lo  (req_wdata[CHAR_W-1:0]),
        .in_valid  (rx_valid),
        .in_data   (rx_data),
        .busy_in   (rx_busy),
        .stat      (rx_stat),
        .char_word (rx_word),
        .irq       (irq_rx)
    );

    conclk_tx_unit u_tx (
        .clk       (clk),
        .rst       (rst),
        .wr_stat   (stb.txs_wr),
        .wr_char   (stb.txb_wr),
        .ack       (irq_ack[1]),
        .wdata_lo  (req_wdata[TX_BITS-1:0]),
        .out_ready (tx_ready),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .stat      (tx_stat),
        .irq       (irq_tx)
    );

    conclk_tick_unit #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .wr_stat (stb.clk_wr),
        .ack     (irq_ack[2]),
        .wctl    ({req_wdata[FLAG_BIT], req_wdata[IE_BIT]}),
        .stat    (clk_stat),
        .irq     (irq_clk)
    );

    always_comb begin
        case (sel)
            SEL_CLK: rd_mux = clk_stat;
            SEL_RXS: rd_mux = rx_stat;
            SEL_RXB: rd_mux = rx_word;
            SEL_TXS: rd_mux = tx_stat;
            SEL_SW:  rd_mux = sw_in;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= hit;
            rsp_rdata <= (hit && !req_write) ? rd_mux : '0;
        end
    end

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    // R2
    rsp_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && decode_addr(req_addr) == SEL_NONE) |=> !rsp_valid);

    // R6
    txb_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && decode_addr(req_addr) == SEL_TXB) |=> rsp_rdata == '0);

endmodule

// File: tb/conclk_regfile_test.sv
module conclk_regfile_test;

    localparam int DIV = 40;
    localparam logic [15:0] SW = 16'hA72E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        rx_valid = 1'b0, rx_busy = 1'b0, tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid;
    logic [6:0]  tx_data;
    logic [2:0]  irq_ack = '0;
    logic        irq_rx, irq_tx, irq_clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    conclk_regfile #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sw_in(SW),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_busy(rx_busy),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .irq_ack(irq_ack), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_clk(irq_clk)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic bus_op(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                          output logic [15:0] rd, output logic got);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        got = rsp_valid; rd = rsp_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [15:0] exp);
        logic [15:0] v; logic g;
        bus_op(1'b0, a, 16'h0000, v, g);
        chk({req, " valid"}, {15'd0, g}, 16'd1);
        chk(req, v, exp);
    endtask

    task automatic wr_op(input logic [15:0] a, input logic [15:0] wd);
        logic [15:0] v; logic g;
        bus_op(1'b1, a, wd, v, g);
    endtask

    task automatic pulse_rx(input logic [7:0] c);
        rx_valid = 1'b1; rx_data = c;
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_ack(input logic [2:0] m);
        irq_ack = m;
        @(posedge clk); @(negedge clk);
        irq_ack = '0;
    endtask

    // {req number, write, address, write data, expected read}
    localparam int NV = 20;
    localparam logic [52:0] VT [0:NV-1] = '{
        {4'd1,  1'b0, 16'o177564, 16'h0000, 16'h0080},  // R1 tx ready after reset
        {4'd1,  1'b0, 16'o177560, 16'h0000, 16'h0000},  // R1
        {4'd1,  1'b0, 16'o177562, 16'h0000, 16'h0000},  // R1
        {4'd3,  1'b1, 16'o177560, 16'h00C3, 16'h0000},  // R3 only bits 6,0 stick
        {4'd3,  1'b0, 16'o177560, 16'h0000, 16'h0041},  // R3
        {4'd6,  1'b1, 16'o177564, 16'h0044, 16'h0000},  // R6 enable + maintenance
        {4'd6,  1'b0, 16'o177564, 16'h0000, 16'h00C4},  // R6
        {4'd6,  1'b0, 16'o177566, 16'h0000, 16'h0000},  // R6 buffer reads zero
        {4'd12, 1'b1, 16'o177570, 16'hFFFF, 16'h0000},  // R12 write ignored
        {4'd12, 1'b0, 16'o177570, 16'h0000, SW},        // R12
        {4'd12, 1'b0, 16'o177571, 16'h0000, SW},        // R12 odd byte too
        {4'd13, 1'b1, 16'o177561, 16'hFFFF, 16'h0000},  // R13
        {4'd13, 1'b0, 16'o177561, 16'h0000, 16'h0000},  // R13
        {4'd13, 1'b0, 16'o177560, 16'h0000, 16'h0041},  // R13 neighbour untouched
        {4'd13, 1'b0, 16'o177547, 16'h0000, 16'h0000},  // R13
        {4'd13, 1'b0, 16'o177563, 16'h0000, 16'h0000},  // R13
        {4'd13, 1'b0, 16'o177565, 16'h0000, 16'h0000},  // R13
        {4'd13, 1'b0, 16'o177567, 16'h0000, 16'h0000},  // R13
        {4'd6,  1'b1, 16'o177564, 16'h0000, 16'h0000},  // R6
        {4'd6,  1'b0, 16'o177564, 16'h0000, 16'h0080}   // R6
    };

    initial begin
        logic [15:0] v;
        logic        g;
        int          cyc;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state at the ports
        chk("R1 rsp_valid", {15'd0, rsp_valid}, 16'd0);
        chk("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
        chk("R1 irqs", {13'd0, irq_rx, irq_tx, irq_clk}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            bus_op(VT[i][48], VT[i][47:32], VT[i][31:16], v, g);
            chk($sformatf("R2 vec %0d valid", i), {15'd0, g}, 16'd1);
            if (!VT[i][48])
                chk($sformatf("R%0d vec %0d", VT[i][52:49], i), v, VT[i][15:0]);
        end

        // R2 addresses outside the map get no response
        bus_op(1'b0, 16'o177000, 16'h0, v, g); chk("R2 unmapped", {15'd0, g}, 16'd0);
        bus_op(1'b0, 16'o077560, 16'h0, v, g); chk("R2 low page", {15'd0, g}, 16'd0);
        bus_op(1'b1, 16'o177550, 16'h0, v, g); chk("R2 unmapped wr", {15'd0, g}, 16'd0);

        // R5 arrival, R11 request with enable set
        pulse_rx(8'h5A);
        chk("R11 irq_rx", {15'd0, irq_rx}, 16'd1);
        rd_chk("R5 status after byte", 16'o177560, 16'h00C0);
        rd_chk("R4 buffer", 16'o177562, 16'h005A);
        rd_chk("R4 drained", 16'o177562, 16'h0000);
        rd_chk("R4 status cleared", 16'o177560, 16'h0040);
        chk("R11 irq_rx low", {15'd0, irq_rx}, 16'd0);

        // R5 byte arrives in the cycle of a buffer read
        pulse_rx(8'h11);
        rx_valid = 1'b1; rx_data = 8'h22;
        bus_op(1'b0, 16'o177562, 16'h0, v, g);
        rx_valid = 1'b0;
        chk("R5 collision old", v, 16'h0011);
        rd_chk("R5 collision new", 16'o177562, 16'h0022);

        // R3 busy bit follows the shifter
        rx_busy = 1'b1;
        rd_chk("R3 busy", 16'o177560, 16'h0042);
        rx_busy = 1'b0;

        // R9 receiver arming
        wr_op(16'o177560, 16'h0000);
        pulse_rx(8'h33);
        pulse_ack(3'b001);
        rd_chk("R9 acked", 16'o177560, 16'h0000);
        wr_op(16'o177560, 16'h0040);
        rd_chk("R9 rx armed", 16'o177560, 16'h00C0);
        chk("R11 irq_rx armed", {15'd0, irq_rx}, 16'd1);
        pulse_ack(3'b001);
        wr_op(16'o177560, 16'h0040);
        rd_chk("R9 rx no rearm", 16'o177560, 16'h0040);
        rd_chk("R4 drain", 16'o177562, 16'h0033);

        // R7 / R8 transmitter
        wr_op(16'o177566, 16'h01C1);
        chk("R7 tx_valid", {15'd0, tx_valid}, 16'd1);
        chk("R7 tx_data", {9'd0, tx_data}, 16'h0041);
        rd_chk("R7 status busy", 16'o177564, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R7 held", {15'd0, tx_valid}, 16'd1);
        tx_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_ready = 1'b0;
        chk("R8 tx_valid low", {15'd0, tx_valid}, 16'd0);
        rd_chk("R8 status ready", 16'o177564, 16'h0080);

        // R9 transmitter arming
        pulse_ack(3'b010);
        rd_chk("R9 tx acked", 16'o177564, 16'h0000);
        wr_op(16'o177564, 16'h0040);
        rd_chk("R9 tx armed", 16'o177564, 16'h00C0);
        chk("R11 irq_tx", {15'd0, irq_tx}, 16'd1);
        wr_op(16'o177564, 16'h0000);

        // R10 line clock
        wr_op(16'o177546, 16'h0040);
        cyc = 0;
        while (!irq_clk && cyc < 3 * DIV) begin
            @(negedge clk); cyc++;
        end
        chk("R10 tick seen", {15'd0, irq_clk}, 16'd1);
        wr_op(16'o177546, 16'h0040);
        chk("R10 cleared", {15'd0, irq_clk}, 16'd0);
        cyc = 1;
        while (!irq_clk && cyc < 3 * DIV) begin
            @(negedge clk); cyc++;
        end
        chk("R10 period", 16'(cyc), 16'(DIV));
        pulse_ack(3'b100);
        chk("R11 irq_clk acked", {15'd0, irq_clk}, 16'd0);
        rd_chk("R11 flag kept", 16'o177546, 16'h00C0);
        wr_op(16'o177546, 16'h00C0);
        rd_chk("R10 write one keeps", 16'o177546, 16'h00C0);
        wr_op(16'o177546, 16'h0000);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule